// File: doc/BRIEF.md
# Shadow Register Upload Controller

This block holds the configuration registers for up to eleven register groups. Each register has two copies. The shadow copy is the one the host writes. The working copy is the one the downstream processing logic reads. A host write goes only into the shadow copy and marks that register as changed. The working copy stays as it was, so the consumers never see a half-programmed group.

When the host writes the upload control word, each bit set to 1 commits one group. In a single cycle, every changed register of that group is copied from its shadow copy to its working copy. The same edge clears the change markers. Bits written as 0 are ignored.

The upload status is a per-group vector. A 1 means the group still holds changes that have not been committed. A single address port reads back both copies of any register, so the host can inspect them.

Top module: `shreg_upload_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every shadow and working register reads 0 and `upld_pending` is all zeros.
- R2: A host write (`wr_en`=1 with `wr_grp` < NUM_GROUPS) updates only the addressed shadow register, visible on `shadow_rdata` after the next clock edge. Working registers change only on an upload.
- R3: After a host write to group g, bit g of `upld_pending` reads 1 from the next clock edge onward, until an upload of g.
- R4: `upld_we`=1 with `upld_mask[g]`=1 copies every changed shadow register of group g into its working register at that clock edge. It also clears bit g of `upld_pending`, provided no host write hits group g in the same cycle.
- R5: An upload touches only the groups whose mask bit is 1. Uploading a group with no pending changes leaves its working registers unchanged.
- R6: A mask bit written as 0 has no effect. The pending flag and the working registers of that group stay unchanged.
- R7: A host write to group g in the same cycle as an upload of g has two results. The working register receives the shadow value from before the write, if that register was pending. The newly written value stays in the shadow copy, and bit g of `upld_pending` stays 1 for the next upload.
- R8: A host write with `wr_grp` >= NUM_GROUPS is ignored. No register and no pending bit changes. A read with `rd_grp` >= NUM_GROUPS returns 0 on both read ports.
- R9: Several mask bits set in one upload write commit all the selected groups in the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe for a shadow register |
| wr_grp | input | GRP_W (4) | Group index of the host write |
| wr_idx | input | IDX_W (2) | Register index within the group |
| wr_data | input | DATA_W (16) | Write data |
| upld_we | input | 1 | Write strobe of the upload control word |
| upld_mask | input | NUM_GROUPS (11) | Upload bits; bit g commits group g |
| upld_pending | output | NUM_GROUPS (11) | Per-group flag for changes not yet uploaded |
| rd_grp | input | GRP_W (4) | Read group index |
| rd_idx | input | IDX_W (2) | Read register index |
| shadow_rdata | output | DATA_W (16) | Shadow copy at the read address |
| work_rdata | output | DATA_W (16) | Working copy at the read address |
| work_bus | output | NUM_GROUPS*REGS_PER_GRP*DATA_W (704) | All working registers for the consumers, group-major |

## Verification
The bound checker watches the pending flags and the working bus on every cycle. It checks four things:
- a write raises its group's flag;
- a flag falls only on an upload of its own group;
- a colliding write keeps the flag set;
- the working bus never moves without an upload strobe.

The data values that reach the working copy need the bench's scenarios. These cover which registers are copied, the old-value-wins rule on a collision, multi-group commits, out-of-range addresses and the return to zero after reset.

// File: rtl/shreg_pkg.sv
// Package: default sizing for the shadow/working register upload controller.
// Assumes REGS_PER_GRP >= 2 so that the register index has at least one bit.
package shreg_pkg;
    localparam int DEF_GROUPS = 11;
    localparam int DEF_REGS   = 4;
    localparam int DEF_DW     = 16;
endpackage

// File: rtl/shreg_cell.sv
// One configuration register: a shadow copy, a working copy and a changed flag.
// Assumes the write and upload strobes are already decoded for this register.
// On a collision the host write wins the shadow copy and the flag. The upload
// still copies the old shadow value into the working copy.
module shreg_cell #(
    parameter int DATA_W = shreg_pkg::DEF_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upld,
    output logic [DATA_W-1:0] shadow_q,
    output logic [DATA_W-1:0] work_q,
    output logic              dirty_q
);
    // Purpose: stage host writes and commit changed contents on upload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            work_q   <= '0;
            dirty_q  <= 1'b0;
        end else begin
            if (upld && dirty_q) begin
                work_q <= shadow_q;
            end
            if (we) begin
                shadow_q <= wdata;
                dirty_q  <= 1'b1;
            end else if (upld) begin
                dirty_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/shreg_group.sv
// One register group: REGS_PER_GRP cells sharing a single upload strobe.
// Assumes the write strobe is already decoded for this group. The pending
// flag is the OR of the cells' changed flags.
module shreg_group #(
    parameter int REGS_PER_GRP = shreg_pkg::DEF_REGS,
    parameter int DATA_W       = shreg_pkg::DEF_DW,
    localparam int IDX_W       = $clog2(REGS_PER_GRP)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                grp_we,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                grp_upld,
    output logic [REGS_PER_GRP-1:0][DATA_W-1:0] shadow_o,
    output logic [REGS_PER_GRP-1:0][DATA_W-1:0] work_o,
    output logic                                pending
);
    logic [REGS_PER_GRP-1:0] dirty;

    for (genvar r = 0; r < REGS_PER_GRP; r++) begin : g_cell
        logic cell_we;
        // Purpose: route the group write to the one addressed register.
        assign cell_we = grp_we && (wr_idx == IDX_W'(r));
        shreg_cell #(.DATA_W(DATA_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (cell_we),
            .wdata    (wr_data),
            .upld     (grp_upld),
            .shadow_q (shadow_o[r]),
            .work_q   (work_o[r]),
            .dirty_q  (dirty[r])
        );
    end

    // Purpose: report whether any register in the group is still uncommitted.
    assign pending = |dirty;
endmodule

// File: rtl/shreg_upload_ctrl.sv
// Top: address decode, per-group storage and read-back for the upload scheme.
// Assumes NUM_GROUPS <= 2**GRP_W. Accesses with a group index at or above
// NUM_GROUPS are ignored on writes and read back as zero.
module shreg_upload_ctrl #(
    parameter int NUM_GROUPS   = shreg_pkg::DEF_GROUPS,
    parameter int REGS_PER_GRP = shreg_pkg::DEF_REGS,
    parameter int DATA_W       = shreg_pkg::DEF_DW,
    localparam int GRP_W       = $clog2(NUM_GROUPS),
    localparam int IDX_W       = $clog2(REGS_PER_GRP),
    localparam int BUS_W       = NUM_GROUPS * REGS_PER_GRP * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GRP_W-1:0]      wr_grp,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  upld_we,
    input  logic [NUM_GROUPS-1:0] upld_mask,
    output logic [NUM_GROUPS-1:0] upld_pending,
    input  logic [GRP_W-1:0]      rd_grp,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     shadow_rdata,
    output logic [DATA_W-1:0]     work_rdata,
    output logic [BUS_W-1:0]      work_bus
);
    localparam logic [GRP_W-1:0] GRP_LIMIT = GRP_W'(NUM_GROUPS - 1);

    logic [NUM_GROUPS-1:0][REGS_PER_GRP-1:0][DATA_W-1:0] sh_all;
    logic [NUM_GROUPS-1:0][REGS_PER_GRP-1:0][DATA_W-1:0] wk_all;
    logic                                                rd_ok;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit_we;
        logic hit_up;
        // Purpose: decode the host write and the upload bit for this group.
        assign hit_we = wr_en && (wr_grp == GRP_W'(g));
        assign hit_up = upld_we && upld_mask[g];
        shreg_group #(
            .REGS_PER_GRP (REGS_PER_GRP),
            .DATA_W       (DATA_W)
        ) u_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .grp_we   (hit_we),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .grp_upld (hit_up),
            .shadow_o (sh_all[g]),
            .work_o   (wk_all[g]),
            .pending  (upld_pending[g])
        );
    end

    // Purpose: return both copies at the read address, zero when out of range.
    assign rd_ok        = (rd_grp <= GRP_LIMIT);
    assign shadow_rdata = rd_ok ? sh_all[rd_grp][rd_idx] : '0;
    assign work_rdata   = rd_ok ? wk_all[rd_grp][rd_idx] : '0;

    // Purpose: expose every working register to the consuming logic.
    assign work_bus = wk_all;
endmodule

// File: rtl/shreg_upload_chk.sv
// Checker for shreg_upload_ctrl, bound to every instance. It only watches the
// top-level ports; it drives nothing.
module shreg_upload_chk #(
    parameter int NUM_GROUPS   = shreg_pkg::DEF_GROUPS,
    parameter int REGS_PER_GRP = shreg_pkg::DEF_REGS,
    parameter int DATA_W       = shreg_pkg::DEF_DW,
    localparam int GRP_W       = $clog2(NUM_GROUPS),
    localparam int BUS_W       = NUM_GROUPS * REGS_PER_GRP * DATA_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [GRP_W-1:0]      wr_grp,
    input logic                  upld_we,
    input logic [NUM_GROUPS-1:0] upld_mask,
    input logic [NUM_GROUPS-1:0] upld_pending,
    input logic [BUS_W-1:0]      work_bus
);
    // R1: the first cycle out of reset shows no pending group.
    assert_reset_clear_R1: assert property (@(posedge clk)
        disable iff (!rst_n) $rose(rst_n) |-> (upld_pending == '0));

    // R2: the working copies change only on a cycle with an upload strobe.
    assert_work_only_on_upload_R2: assert property (@(posedge clk)
        disable iff (!rst_n) !upld_we |=> $stable(work_bus));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R3: a write into group g raises its pending flag.
        assert_write_sets_pending_R3: assert property (@(posedge clk)
            disable iff (!rst_n) (wr_en && wr_grp == GRP_W'(g)) |=> upld_pending[g]);

        // R4: an upload of g with no colliding write clears the flag.
        assert_upload_clears_R4: assert property (@(posedge clk)
            disable iff (!rst_n)
            (upld_we && upld_mask[g] && !(wr_en && wr_grp == GRP_W'(g))) |=> !upld_pending[g]);

        // R6: a flag falls only when its own upload bit is written as 1.
        assert_no_silent_clear_R6: assert property (@(posedge clk)
            disable iff (!rst_n)
            (upld_pending[g] && !(upld_we && upld_mask[g])) |=> upld_pending[g]);

        // R7: a write colliding with the upload keeps the group pending.
        assert_collision_stays_pending_R7: assert property (@(posedge clk)
            disable iff (!rst_n)
            (upld_we && upld_mask[g] && wr_en && wr_grp == GRP_W'(g)) |=> upld_pending[g]);

        // R8: a pending flag rises only from a write addressed to its group.
        assert_no_spurious_pending_R8: assert property (@(posedge clk)
            disable iff (!rst_n)
            (!upld_pending[g] && !(wr_en && wr_grp == GRP_W'(g))) |=> !upld_pending[g]);
    end
endmodule

bind shreg_upload_ctrl shreg_upload_chk #(
    .NUM_GROUPS   (NUM_GROUPS),
    .REGS_PER_GRP (REGS_PER_GRP),
    .DATA_W       (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_grp       (wr_grp),
    .upld_we      (upld_we),
    .upld_mask    (upld_mask),
    .upld_pending (upld_pending),
    .work_bus     (work_bus)
);

// File: tb/shreg_upload_ctrl_test.sv
// Bench for shreg_upload_ctrl: a walked vector table, then reset directed tests.
module shreg_upload_ctrl_test;
    localparam int NG = 11;
    localparam int NR = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_grp = '0;
    logic [1:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          upld_we = 1'b0;
    logic [NG-1:0] upld_mask = '0;
    logic [NG-1:0] upld_pending;
    logic [3:0]    rd_grp = '0;
    logic [1:0]    rd_idx = '0;
    logic [DW-1:0] shadow_rdata;
    logic [DW-1:0] work_rdata;
    logic [NG*NR*DW-1:0] work_bus;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    shreg_upload_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_idx(wr_idx), .wr_data(wr_data), .upld_we(upld_we),
        .upld_mask(upld_mask), .upld_pending(upld_pending),
        .rd_grp(rd_grp), .rd_idx(rd_idx), .shadow_rdata(shadow_rdata),
        .work_rdata(work_rdata), .work_bus(work_bus)
    );

    typedef struct packed {
        logic          we;
        logic [3:0]    grp;
        logic [1:0]    idx;
        logic [DW-1:0] data;
        logic          up;
        logic [NG-1:0] mask;
        logic [3:0]    cg;
        logic [1:0]    ci;
        logic [DW-1:0] exp_sh;
        logic [DW-1:0] exp_wk;
        logic [NG-1:0] exp_pd;
    } vec_t;

    // we grp idx data | up mask | check grp idx | shadow work pending
    localparam vec_t VECS [13] = '{
        '{1'b1, 4'd0,  2'd1, 16'h1111, 1'b0, 11'h000, 4'd0,  2'd1, 16'h1111, 16'h0000, 11'h001}, // R2 R3
        '{1'b1, 4'd0,  2'd2, 16'h2222, 1'b0, 11'h000, 4'd0,  2'd2, 16'h2222, 16'h0000, 11'h001}, // R2 R3
        '{1'b0, 4'd0,  2'd0, 16'h0000, 1'b1, 11'h000, 4'd0,  2'd1, 16'h1111, 16'h0000, 11'h001}, // R6
        '{1'b0, 4'd0,  2'd0, 16'h0000, 1'b1, 11'h002, 4'd0,  2'd1, 16'h1111, 16'h0000, 11'h001}, // R5
        '{1'b0, 4'd0,  2'd0, 16'h0000, 1'b1, 11'h001, 4'd0,  2'd1, 16'h1111, 16'h1111, 11'h000}, // R4
        '{1'b0, 4'd0,  2'd0, 16'h0000, 1'b0, 11'h000, 4'd0,  2'd2, 16'h2222, 16'h2222, 11'h000}, // R4
        '{1'b1, 4'd3,  2'd0, 16'hA5A5, 1'b0, 11'h000, 4'd3,  2'd0, 16'hA5A5, 16'h0000, 11'h008}, // R3
        '{1'b1, 4'd10, 2'd3, 16'hBEEF, 1'b0, 11'h000, 4'd10, 2'd3, 16'hBEEF, 16'h0000, 11'h408}, // R3
        '{1'b0, 4'd0,  2'd0, 16'h0000, 1'b1, 11'h408, 4'd10, 2'd3, 16'hBEEF, 16'hBEEF, 11'h000}, // R9
        '{1'b1, 4'd2,  2'd0, 16'h0101, 1'b0, 11'h000, 4'd2,  2'd0, 16'h0101, 16'h0000, 11'h004}, // R3
        '{1'b1, 4'd2,  2'd0, 16'h0202, 1'b1, 11'h004, 4'd2,  2'd0, 16'h0202, 16'h0101, 11'h004}, // R7
        '{1'b0, 4'd0,  2'd0, 16'h0000, 1'b1, 11'h004, 4'd2,  2'd0, 16'h0202, 16'h0202, 11'h004 & 11'h000}, // R7
        '{1'b1, 4'd12, 2'd0, 16'hFFFF, 1'b0, 11'h000, 4'd12, 2'd0, 16'h0000, 16'h0000, 11'h000}  // R8
    };

    // Purpose: count one comparison and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Purpose: drive one host write and/or upload across a single clock edge.
    task automatic step(input logic we, input logic [3:0] g, input logic [1:0] i,
                        input logic [DW-1:0] d, input logic up, input logic [NG-1:0] m);
        wr_en = we; wr_grp = g; wr_idx = i; wr_data = d;
        upld_we = up; upld_mask = m;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; upld_we = 1'b0; upld_mask = '0;
    endtask

    // Purpose: read both copies of one register after the outputs settle.
    task automatic peek(input logic [3:0] g, input logic [1:0] i);
        rd_grp = g; rd_idx = i;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: every copy and flag reads zero while held in reset.
        peek(4'd0, 2'd0);
        check("R1 pending", 32'(upld_pending), 32'h0);
        check("R1 work_bus", 32'(|work_bus), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[k]) begin
            step(VECS[k].we, VECS[k].grp, VECS[k].idx, VECS[k].data, VECS[k].up, VECS[k].mask);
            peek(VECS[k].cg, VECS[k].ci);
            check($sformatf("R2-R9 vec%0d shadow", k), 32'(shadow_rdata), 32'(VECS[k].exp_sh));
            check($sformatf("R2-R9 vec%0d work", k),   32'(work_rdata),   32'(VECS[k].exp_wk));
            check($sformatf("R2-R9 vec%0d pending", k), 32'(upld_pending), 32'(VECS[k].exp_pd));
        end

        // R8: the out-of-range write left group 1 index 0 untouched.
        peek(4'd1, 2'd0);
        check("R8 g1 shadow", 32'(shadow_rdata), 32'h0);

        // R1: dirty a group, then reset; all copies and flags must clear.
        step(1'b1, 4'd5, 2'd1, 16'h5A5A, 1'b0, '0);
        step(1'b0, 4'd0, 2'd0, 16'h0, 1'b1, 11'h020);
        step(1'b1, 4'd5, 2'd1, 16'h7777, 1'b0, '0);
        peek(4'd5, 2'd1);
        check("R4 g5 work before reset", 32'(work_rdata), 32'h5A5A);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        peek(4'd5, 2'd1);
        check("R1 g5 shadow", 32'(shadow_rdata), 32'h0);
        check("R1 g5 work", 32'(work_rdata), 32'h0);
        check("R1 pending", 32'(upld_pending), 32'h0);
        check("R1 work_bus", 32'(|work_bus), 32'h0);

        // R5: an upload of a clean group after reset leaves it at zero.
        step(1'b0, 4'd0, 2'd0, 16'h0, 1'b1, 11'h7FF);
        peek(4'd0, 2'd1);
        check("R5 clean upload work", 32'(work_rdata), 32'h0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Purpose: end a hung run as a failure.
    initial begin
        #(20000 * 10);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule